// File: doc/BRIEF.md
# Asynchronous Packet Header Inserter

This block assembles one outgoing asynchronous serial-bus packet at a time. A microcontroller stores header quadlets in four 32-bit registers, one register write per quadlet. A start pulse then sends the header quadlets, in ascending order, to a transmitter over a valid/ready stream. After the header, the block sends a number of payload quadlets that it fetches from an external memory through a data-mover port. The `tx_last` flag marks the final quadlet of the packet.

The header is three or four quadlets long, chosen by a mode input that the block samples at start. The payload is fetched one quadlet at a time. The block pulses `pf_req`, and the memory presents the requested quadlet on `mem_data` during the next cycle, where the block takes it. The first request is made in the cycle the last header quadlet is accepted, so the payload follows the header with no idle cycle. When the transmitter stalls, the block holds the quadlet it is offering. Header registers written while a packet is in flight do not change that packet.

The control is a three-state machine:
- **IDLE**: no packet.
- **HDR**: header quadlets are offered.
- **PAY**: payload quadlets are offered.

The transitions are:
- **IDLE→HDR** on a start pulse.
- **HDR→HDR** when a header quadlet that is not the last is accepted.
- **HDR→PAY** when the last header quadlet is accepted and the payload length is non-zero.
- **HDR→IDLE** when the last header quadlet is accepted and the payload length is zero.
- **PAY→PAY** when a payload quadlet that is not the last is accepted.
- **PAY→IDLE** when the final payload quadlet is accepted.

Top module: `async_hdr_inserter`

## Requirements
- R1: A write with `cfg_wr`=1 loads header quadlet 0, 1, 2 or 3 when `cfg_addr` is 38h, 3Ch, 40h or 44h. Each write replaces all 32 bits of one quadlet.
- R2: A write to any other `cfg_addr` value changes no header quadlet.
- R3: The block samples `blk_mode` at start. With `blk_mode`=0 it sends header quadlets 0..2. With `blk_mode`=1 it sends header quadlets 0..3.
- R4: All header quadlets are sent in ascending index order before any payload quadlet. The payload quadlets are the `mem_data` words, in the order they were fetched.
- R5: When the payload length is non-zero, `pf_req` is high in the cycle the last header quadlet is accepted. After each `pf_req` cycle, the block takes `mem_data` in the next cycle and offers it on `tx_data` in that same cycle. It issues exactly one `pf_req` per payload quadlet.
- R6: With `pay_len`=0, the block issues no `pf_req` and sets `tx_last` on the last header quadlet.
- R7: With `pay_len`=N>0, the block sends exactly N payload quadlets. `tx_last` is high only on the Nth payload quadlet.
- R8: While `tx_valid`=1 and `tx_ready`=0, the next cycle keeps `tx_valid` high and keeps `tx_data` and `tx_last` unchanged.
- R9: A header write made after the start cycle does not change the packet in flight. It does apply to the next packet.
- R10: `busy` goes high in the cycle after an accepted start and falls in the cycle after the quadlet flagged `tx_last` is accepted. A start pulse while `busy` is high is ignored.
- R11: After reset, `busy`, `tx_valid` and `pf_req` are low and all header quadlets are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Header register write strobe |
| cfg_addr | input | 8 | Byte offset of the register write |
| cfg_wdata | input | 32 | Register write data |
| blk_mode | input | 1 | 1 = four-quadlet header, 0 = three-quadlet header |
| start | input | 1 | Begin a packet (pulse) |
| pay_len | input | 12 | Number of payload quadlets |
| tx_valid | output | 1 | Quadlet offered to transmitter |
| tx_ready | input | 1 | Transmitter accepts quadlet |
| tx_data | output | 32 | Offered quadlet |
| tx_last | output | 1 | Offered quadlet ends the packet |
| pf_req | output | 1 | Request one payload quadlet from memory |
| mem_data | input | 32 | Payload quadlet, valid the cycle after `pf_req` |
| busy | output | 1 | Packet in progress |

## Verification
- **First header quadlet:** it appears on `tx_data` in the cycle after the edge that samples start, and `busy` rises in that same cycle.
- **First payload quadlet:** when `tx_ready` is held high, it is accepted exactly one cycle after the last header quadlet, and `pf_req` is high in that last-header cycle.
- **End of packet:** `busy` is low one cycle after the `tx_last` acceptance.
- **Sampling:** the bench drives inputs on the falling edge and samples outputs one nanosecond before the rising edge. It records the cycle number of every acceptance and every `pf_req`, so each latency is compared as an exact cycle difference.
- **Memory model:** it drives `mem_data` only in the cycle after a sampled `pf_req` and drives a marker value in all other cycles. A quadlet taken on the wrong cycle therefore shows up as a data mismatch.

// File: rtl/hdr_ins_pkg.sv
package hdr_ins_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/hdr_regfile.sv
// Header quadlet storage: a CPU-facing copy that takes register writes at any
// time, and a packet copy frozen when a packet starts.
module hdr_regfile #(
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 8,
    parameter int          HDR_MAX  = 4,
    parameter int unsigned HDR_BASE = 'h38,
    localparam int         IDX_W    = (HDR_MAX > 1) ? $clog2(HDR_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              snap,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cpu_copy [HDR_MAX];
    logic [DATA_W-1:0] pkt_copy [HDR_MAX];

    for (genvar gi = 0; gi < HDR_MAX; gi++) begin : g_quad
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(HDR_BASE + 4 * gi);
        logic hit;
        assign hit = wr_en && (wr_addr == SLOT_ADDR);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cpu_copy[gi] <= '0;
            end else if (hit) begin
                cpu_copy[gi] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pkt_copy[gi] <= '0;
            end else if (snap) begin
                pkt_copy[gi] <= cpu_copy[gi];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < HDR_MAX; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = pkt_copy[i];
            end
        end
    end

endmodule

// File: rtl/pay_slot.sv
// One-quadlet payload slot. The quadlet shows on the output in the cycle after
// a fetch request (bypass) and is parked in a hold register if not taken.
module pay_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              take,
    output logic              slot_valid,
    output logic [DATA_W-1:0] slot_data
);

    logic              arrive;
    logic              park_valid;
    logic [DATA_W-1:0] park_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arrive <= 1'b0;
        end else begin
            arrive <= fetch;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            park_valid <= 1'b0;
            park_data  <= '0;
        end else if (arrive && !take) begin
            park_valid <= 1'b1;
            park_data  <= mem_data;
        end else if (take) begin
            park_valid <= 1'b0;
        end
    end

    assign slot_valid = arrive || park_valid;
    assign slot_data  = park_valid ? park_data : mem_data;

endmodule

// File: rtl/hdr_seq_fsm.sv
// Packet sequencer: header phase, payload phase, framing and fetch timing.
module hdr_seq_fsm
    import hdr_ins_pkg::*;
#(
    parameter int  HDR_MAX = 4,
    parameter int  LEN_W   = 12,
    localparam int IDX_W   = (HDR_MAX > 1) ? $clog2(HDR_MAX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             blk_mode,
    input  logic [LEN_W-1:0] pay_len,
    input  logic             tx_ready,
    input  logic             slot_valid,
    output logic [IDX_W-1:0] hdr_idx,
    output logic             hdr_sel,
    output logic             snap,
    output logic             pf_req,
    output logic             pay_take,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             busy
);

    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(HDR_MAX - 1);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(HDR_MAX - 2);
    localparam logic [LEN_W-1:0] ONE_LEN    = LEN_W'(1);

    seq_state_e       state_q, state_d;
    logic             mode_q;
    logic             nolen_q;
    logic [LEN_W-1:0] req_left_q;
    logic [LEN_W-1:0] acc_left_q;
    logic [IDX_W-1:0] last_idx;
    logic             hdr_fin;
    logic             pay_fin;

    assign last_idx = mode_q ? LAST_LONG : LAST_SHORT;
    assign hdr_fin  = (state_q == ST_HDR) && tx_ready && (hdr_idx == last_idx);
    assign pay_fin  = pay_take && (acc_left_q == ONE_LEN);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)   state_d = ST_HDR;
            ST_HDR:  if (hdr_fin) state_d = nolen_q ? ST_IDLE : ST_PAY;
            ST_PAY:  if (pay_fin) state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // packet context and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= 1'b0;
            nolen_q    <= 1'b1;
            hdr_idx    <= '0;
            req_left_q <= '0;
            acc_left_q <= '0;
        end else begin
            if (snap) begin
                mode_q     <= blk_mode;
                nolen_q    <= (pay_len == '0);
                hdr_idx    <= '0;
                req_left_q <= pay_len;
                acc_left_q <= pay_len;
            end else begin
                if ((state_q == ST_HDR) && tx_ready && !hdr_fin) begin
                    hdr_idx <= hdr_idx + IDX_W'(1);
                end
                if (pf_req) begin
                    req_left_q <= req_left_q - ONE_LEN;
                end
                if (pay_take) begin
                    acc_left_q <= acc_left_q - ONE_LEN;
                end
            end
        end
    end

    // outputs
    always_comb begin
        snap     = 1'b0;
        hdr_sel  = 1'b0;
        pf_req   = 1'b0;
        pay_take = 1'b0;
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                snap = start;
            end
            ST_HDR: begin
                hdr_sel  = 1'b1;
                tx_valid = 1'b1;
                tx_last  = nolen_q && (hdr_idx == last_idx);
                pf_req   = hdr_fin && !nolen_q;
            end
            ST_PAY: begin
                tx_valid = slot_valid;
                tx_last  = slot_valid && (acc_left_q == ONE_LEN);
                pay_take = slot_valid && tx_ready;
                pf_req   = (req_left_q != '0) && (!slot_valid || tx_ready);
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/async_hdr_inserter.sv
module async_hdr_inserter #(
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 8,
    parameter int          LEN_W    = 12,
    parameter int          HDR_MAX  = 4,
    parameter int unsigned HDR_BASE = 'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              blk_mode,
    input  logic              start,
    input  logic [LEN_W-1:0]  pay_len,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_last,
    output logic              pf_req,
    input  logic [DATA_W-1:0] mem_data,
    output logic              busy
);

    localparam int IDX_W = (HDR_MAX > 1) ? $clog2(HDR_MAX) : 1;

    logic [IDX_W-1:0]  hdr_idx;
    logic [DATA_W-1:0] hdr_word;
    logic [DATA_W-1:0] slot_data;
    logic              slot_valid;
    logic              hdr_sel;
    logic              snap;
    logic              pay_take;

    hdr_regfile #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .HDR_MAX (HDR_MAX),
        .HDR_BASE(HDR_BASE)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr),
        .wr_addr(cfg_addr),
        .wr_data(cfg_wdata),
        .snap   (snap),
        .rd_idx (hdr_idx),
        .rd_data(hdr_word)
    );

    hdr_seq_fsm #(
        .HDR_MAX(HDR_MAX),
        .LEN_W  (LEN_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .blk_mode  (blk_mode),
        .pay_len   (pay_len),
        .tx_ready  (tx_ready),
        .slot_valid(slot_valid),
        .hdr_idx   (hdr_idx),
        .hdr_sel   (hdr_sel),
        .snap      (snap),
        .pf_req    (pf_req),
        .pay_take  (pay_take),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .busy      (busy)
    );

    pay_slot #(
        .DATA_W(DATA_W)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch     (pf_req),
        .mem_data  (mem_data),
        .take      (pay_take),
        .slot_valid(slot_valid),
        .slot_data (slot_data)
    );

    assign tx_data = hdr_sel ? hdr_word : slot_data;

endmodule

// File: rtl/async_hdr_inserter_chk.sv
module async_hdr_inserter_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_last,
    input logic              pf_req,
    input logic              busy
);

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last))
        else $error("stalled quadlet changed");

    p_fetch_then_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pf_req |=> tx_valid)
        else $error("no quadlet offered after fetch request");

    p_fetch_in_packet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pf_req |-> busy)
        else $error("fetch request outside a packet");

    p_last_is_offered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid)
        else $error("end marker without valid");

    p_end_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> !busy)
        else $error("busy after end of packet");

    p_start_sets_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy)
        else $error("start did not raise busy");

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_valid && !pf_req)
        else $error("activity while idle");

endmodule

bind async_hdr_inserter async_hdr_inserter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .tx_data (tx_data),
    .tx_last (tx_last),
    .pf_req  (pf_req),
    .busy    (busy)
);

// File: tb/sim_async_hdr_inserter.sv
`timescale 1ns/1ps
module sim_async_hdr_inserter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        blk_mode = 1'b0;
    logic        start = 1'b0;
    logic [11:0] pay_len = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [31:0] tx_data;
    logic        tx_last;
    logic        pf_req;
    logic [31:0] mem_data = '0;
    logic        busy;

    always #5 clk = ~clk;

    async_hdr_inserter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .blk_mode(blk_mode), .start(start),
        .pay_len(pay_len), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .pf_req(pf_req),
        .mem_data(mem_data), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // link-side model state
    int          ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    int          cyc = 0;
    logic [31:0] pay_mem [64];
    int          pay_rd = 0;
    bit          pf_pend = 1'b0;
    logic [31:0] got_data [64];
    bit          got_last [64];
    int          acc_cyc [64];
    int          nbeats = 0;
    int          pf_cnt = 0;
    int          pf_first = -1;
    int          hold_err = 0;
    bit          prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    bit          prev_last = 1'b0;
    bit          after_last = 1'b0;
    bit          busy_post = 1'b1;
    logic [31:0] hq [4];

    // memory, transmitter and monitor: drive at falling edge, sample 1 ns before rising edge
    always begin
        @(negedge clk);
        mem_data = pf_pend ? pay_mem[pay_rd] : (32'hBAD0_0000 | 32'(cyc));
        if (pf_pend) pay_rd++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ready_mode)
            1:       tx_ready = cyc[0];
            2:       tx_ready = lfsr[0];
            default: tx_ready = 1'b1;
        endcase
        #4;
        if (after_last) begin
            busy_post  = busy;
            after_last = 1'b0;
        end
        if (prev_stall && !(tx_valid && tx_data == prev_data && tx_last == prev_last))
            hold_err++;
        prev_stall = tx_valid && !tx_ready;
        prev_data  = tx_data;
        prev_last  = tx_last;
        if (tx_valid && tx_ready && nbeats < 64) begin
            got_data[nbeats] = tx_data;
            got_last[nbeats] = tx_last;
            acc_cyc[nbeats]  = cyc;
            nbeats++;
            if (tx_last) after_last = 1'b1;
        end
        if (pf_req) begin
            if (pf_cnt == 0) pf_first = cyc;
            pf_cnt++;
        end
        pf_pend = pf_req;
        cyc++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic load_hdrs(input logic [31:0] base);
        for (int i = 0; i < 4; i++) begin
            hq[i] = base + 32'(i * 16 + 1);
            cfg_write(8'(8'h38 + 4 * i), hq[i]);
        end
    endtask

    task automatic begin_pkt(input bit mode, input int len, input int rmode, input int seed);
        @(negedge clk);
        nbeats = 0; pf_cnt = 0; pf_first = -1; pay_rd = 0; hold_err = 0;
        busy_post = 1'b1;
        ready_mode = rmode;
        for (int i = 0; i < 64; i++) pay_mem[i] = 32'hC000_0000 + 32'(seed * 256 + i);
        start = 1'b1; blk_mode = mode; pay_len = 12'(len);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_beats(input int n, input string req);
        int w = 0;
        while (nbeats < n && w < 3000) begin
            @(negedge clk);
            w++;
        end
        repeat (3) @(negedge clk);
        check(w < 3000, req, "packet completes", 32'(nbeats), 32'(n));
    endtask

    task automatic check_pkt(input string req, input bit mode, input int len, input int seed);
        int h = mode ? 4 : 3;
        int n = h + len;
        check(nbeats == n, req, "quadlet count", 32'(nbeats), 32'(n));
        check(pf_cnt == len, req, "fetch request count", 32'(pf_cnt), 32'(len));
        for (int i = 0; i < n && i < nbeats; i++) begin
            logic [31:0] e;
            e = (i < h) ? hq[i] : 32'hC000_0000 + 32'(seed * 256 + i - h);
            check(got_data[i] == e, req, $sformatf("quadlet %0d", i), got_data[i], e);
            check(got_last[i] == (i == n - 1), req, $sformatf("end marker %0d", i),
                  32'(got_last[i]), 32'(i == n - 1));
        end
    endtask

    task automatic t_reset;
        #1;
        check(busy == 1'b0, "R11", "busy after reset", 32'(busy), 0);
        check(tx_valid == 1'b0, "R11", "tx_valid after reset", 32'(tx_valid), 0);
        check(pf_req == 1'b0, "R11", "pf_req after reset", 32'(pf_req), 0);
        for (int i = 0; i < 4; i++) hq[i] = '0;
        begin_pkt(1'b0, 0, 0, 0);
        wait_beats(3, "R11");
        check_pkt("R11_R6", 1'b0, 0, 0);
    endtask

    task automatic t_quad_mode;
        load_hdrs(32'h1111_0000);
        begin_pkt(1'b0, 4, 0, 1);
        #4;
        check(busy == 1'b1, "R10", "busy after start", 32'(busy), 1);
        check(tx_valid && tx_data == hq[0], "R4", "first header offered", tx_data, hq[0]);
        wait_beats(7, "R3");
        check_pkt("R1_R3_R4_R7", 1'b0, 4, 1);
        check(pf_first == acc_cyc[2], "R5", "fetch in last header cycle",
              32'(pf_first), 32'(acc_cyc[2]));
        check(acc_cyc[3] == acc_cyc[2] + 1, "R5", "payload follows without gap",
              32'(acc_cyc[3]), 32'(acc_cyc[2] + 1));
    endtask

    task automatic t_block_mode;
        begin_pkt(1'b1, 3, 0, 2);
        wait_beats(7, "R3");
        check_pkt("R3_R5", 1'b1, 3, 2);
        check(pf_first == acc_cyc[3], "R5", "fetch on fourth header",
              32'(pf_first), 32'(acc_cyc[3]));
    endtask

    task automatic t_zero_len;
        begin_pkt(1'b1, 0, 0, 3);
        wait_beats(4, "R6");
        check_pkt("R6", 1'b1, 0, 3);
        check(busy_post == 1'b0, "R10", "busy falls after end", 32'(busy_post), 0);
    endtask

    task automatic t_backpressure;
        begin_pkt(1'b1, 5, 1, 4);
        wait_beats(9, "R8");
        check_pkt("R8", 1'b1, 5, 4);
        check(hold_err == 0, "R8", "stall hold (alternating)", 32'(hold_err), 0);
        begin_pkt(1'b0, 9, 2, 5);
        wait_beats(12, "R8");
        check_pkt("R8_R7", 1'b0, 9, 5);
        check(hold_err == 0, "R8", "stall hold (irregular)", 32'(hold_err), 0);
    endtask

    task automatic t_ignored_offset;
        cfg_write(8'h48, 32'hDEAD_0001);
        cfg_write(8'h34, 32'hDEAD_0002);
        cfg_write(8'h39, 32'hDEAD_0003);
        cfg_write(8'h3E, 32'hDEAD_0004);
        begin_pkt(1'b1, 1, 0, 6);
        wait_beats(5, "R2");
        check_pkt("R2", 1'b1, 1, 6);
    endtask

    task automatic t_write_during;
        logic [31:0] newq;
        newq = 32'h5A5A_0F0F;
        begin_pkt(1'b1, 8, 1, 7);
        cfg_write(8'h38, newq);
        cfg_write(8'h44, ~newq);
        wait_beats(12, "R9");
        check_pkt("R9", 1'b1, 8, 7);
        hq[0] = newq;
        hq[3] = ~newq;
        begin_pkt(1'b1, 1, 0, 8);
        wait_beats(5, "R9");
        check_pkt("R9_R1", 1'b1, 1, 8);
    endtask

    task automatic t_busy_restart;
        begin_pkt(1'b0, 4, 0, 9);
        @(negedge clk);
        start = 1'b1; pay_len = 12'd1; blk_mode = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_beats(7, "R10");
        repeat (6) @(negedge clk);
        check(nbeats == 7, "R10", "start while busy ignored", 32'(nbeats), 7);
        check(busy == 1'b0, "R10", "idle after packet", 32'(busy), 0);
        check(busy_post == 1'b0, "R10", "busy low cycle after end", 32'(busy_post), 0);
        check(got_last[6] == 1'b1, "R7", "end marker on final payload", 32'(got_last[6]), 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_quad_mode();
        t_block_mode();
        t_zero_len();
        t_backpressure();
        t_ignored_offset();
        t_write_during();
        t_busy_restart();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule